// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a bank of one-bit token flags that a left and a right port share. Each flag can be owned by at most one port. A port asks for a flag by writing 0 on data bit 0. It gives the flag back, or cancels a request it has not yet been granted, by writing 1. A port tests ownership by reading the flag. The read value is 0 when that port holds the token and 1 in every other case, and that bit is repeated across the whole data word.

A request that cannot be granted at once is not lost. It is kept as pending and turns into ownership on the clock edge where the holder gives the flag back. When both ports ask for the same free flag in one clock cycle, the left port wins and the right request is recorded as pending. Software built on this bank can therefore request a flag once and poll it until the read returns 0.

A port takes part in a flag access only while its select input is low and its enable input is high. Each port's read data is a combinational view of the registered flag state at the port's current address. A write takes effect on the rising clock edge and can be seen from the next cycle. A synchronous reset frees every flag and clears all pending requests.

Top module: `sem_flag_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every flag becomes free with no pending request, so both ports then read all ones at every address.
- R2: A port changes state only when its `*_sel_n` is 0, its `*_en` is 1 and its `*_wr_n` is 0 at the edge. A write with `*_sel_n` = 1 has no effect. A write with `*_sel_n` = 0 and `*_en` = 0 (the illegal combination) has no effect.
- R3: Only address bits [2:0] choose the flag (8 flags by default). All higher address bits are ignored.
- R4: Writing 0 to a free flag makes the writer the owner. From the next cycle the writer reads 0 and the other port reads 1.
- R5: A write uses only data bit 0: 0 requests and 1 releases or withdraws. The other data bits have no effect.
- R6: A port writing 0 while the other port holds the flag leaves the holder unchanged. The writer keeps reading 1 and its request becomes pending.
- R7: When the holder writes 1 while the other port has a request pending, the other port owns the flag from the next cycle.
- R8: A pending port writing 1 withdraws its request. A later release by the holder then leaves the flag free, and both ports read 1.
- R9: When both ports write 0 to the same free flag in one cycle, the left port becomes owner and the right request becomes pending.
- R10: No flag ever reads 0 on both ports at once.
- R11: Every read returns the flag bit repeated on all `DW` data bits (all zeros or all ones).
- R12: Flags are independent. An operation on one flag never changes the state of any other flag, including when the two ports work on different flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_sel_n | input | 1 | Left flag-bank select, active low |
| l_en | input | 1 | Left enable; must be high for a flag access |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_addr | input | AW | Left address; bits [2:0] pick the flag |
| l_wdata | input | DW | Left write data; only bit 0 is used |
| l_rdata | output | DW | Left read data, flag value replicated |
| r_sel_n | input | 1 | Right flag-bank select, active low |
| r_en | input | 1 | Right enable; must be high for a flag access |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_addr | input | AW | Right address; bits [2:0] pick the flag |
| r_wdata | input | DW | Right write data; only bit 0 is used |
| r_rdata | output | DW | Right read data, flag value replicated |

## Verification
The bench uses the default parameters: 8 flags, a 14-bit address and a 16-bit data word. Each flag has only five reachable states (free, left owner, right owner, and each owner with the other port pending). With these sizes, every flag of both ports can be read back after every clock edge. A long pseudo-random sequence of request, release, illegal-select, deselected and read operations on both ports therefore covers every state transition of every flag, including same-cycle collisions on one flag and traffic on separate flags. Random high address bits and random upper data bits are applied throughout to confirm that they are ignored.

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
  parameter int NFLAGS = 8,
  parameter int AW     = 14,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_sel_n,
  input  logic          l_en,
  input  logic          l_wr_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_sel_n,
  input  logic          r_en,
  input  logic          r_wr_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  localparam int SW = $clog2(NFLAGS);

  logic [NFLAGS-1:0] own_l, own_r, req_l, req_r;
  logic [NFLAGS-1:0] l_ask, l_drop, r_ask, r_drop;

  wire l_go = ~l_sel_n & l_en & ~l_wr_n;
  wire r_go = ~r_sel_n & r_en & ~r_wr_n;
  wire [SW-1:0] l_idx = l_addr[SW-1:0];
  wire [SW-1:0] r_idx = r_addr[SW-1:0];

  logic unused_bits;
  assign unused_bits = ^{l_addr[AW-1:SW], r_addr[AW-1:SW], l_wdata[DW-1:1], r_wdata[DW-1:1]};

  assign l_rdata = {DW{~own_l[l_idx]}};
  assign r_rdata = {DW{~own_r[r_idx]}};

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    wire l_hit = l_go && (l_idx == SW'(i));
    wire r_hit = r_go && (r_idx == SW'(i));
    assign l_ask[i]  = l_hit & ~l_wdata[0];
    assign l_drop[i] = l_hit &  l_wdata[0];
    assign r_ask[i]  = r_hit & ~r_wdata[0];
    assign r_drop[i] = r_hit &  r_wdata[0];

    wire req_l_n = l_ask[i] | (req_l[i] & ~l_drop[i]);
    wire req_r_n = r_ask[i] | (req_r[i] & ~r_drop[i]);
    wire keep_l  = own_l[i] & req_l_n;
    wire keep_r  = own_r[i] & req_r_n;

    always_ff @(posedge clk) begin
      if (rst) begin
        own_l[i] <= 1'b0;
        own_r[i] <= 1'b0;
        req_l[i] <= 1'b0;
        req_r[i] <= 1'b0;
      end else begin
        req_l[i] <= req_l_n;
        req_r[i] <= req_r_n;
        own_l[i] <= req_l_n & (keep_l | ~keep_r);
        own_r[i] <= req_r_n & (keep_r | (~keep_l & ~req_l_n));
      end
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
      !(own_l[i] && own_r[i]));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (own_l[i] && !l_drop[i] && r_ask[i]) |=> (own_l[i] && !own_r[i] && req_r[i]));

    p_handoff_r7: assert property (@(posedge clk) disable iff (rst)
      (own_l[i] && req_r[i] && l_drop[i] && !r_drop[i]) |=> own_r[i]);

    p_tie_r9: assert property (@(posedge clk) disable iff (rst)
      (!own_l[i] && !own_r[i] && !req_l[i] && !req_r[i] && l_ask[i] && r_ask[i])
        |=> (own_l[i] && req_r[i] && !own_r[i]));

    p_withdraw_r8: assert property (@(posedge clk) disable iff (rst)
      (!own_r[i] && r_drop[i]) |=> !req_r[i]);
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (own_l == '0 && own_r == '0 && req_l == '0 && req_r == '0));

  p_repl_r11: assert property (@(posedge clk) disable iff (rst)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  p_noact_r2: assert property (@(posedge clk) disable iff (rst)
    (!l_go && !r_go) |=> ($stable(own_l) && $stable(own_r) && $stable(req_l) && $stable(req_r)));
endmodule

// File: tb/sem_flag_bank_test.sv
`timescale 1ns/1ps
module sem_flag_bank_test;
  localparam int NF = 8, AW = 14, DW = 16;
  localparam int FREE = 0, LO = 1, RO = 2, LO_RP = 3, RO_LP = 4;
  localparam int OP_IDLE = 0, OP_REQ = 1, OP_REL = 2, OP_BAD = 3, OP_DESEL = 4, OP_RD = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic l_sel_n, l_en, l_wr_n, r_sel_n, r_en, r_wr_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  int st [NF];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  sem_flag_bank #(.NFLAGS(NF), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst),
    .l_sel_n(l_sel_n), .l_en(l_en), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_en(r_en), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  function automatic logic [15:0] nxt(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int model(int s, bit lq, bit lr, bit rq, bit rr);
    case (s)
      FREE:    return lq ? (rq ? LO_RP : LO) : (rq ? RO : FREE);
      LO:      return lr ? (rq ? RO : FREE) : (rq ? LO_RP : LO);
      LO_RP:   return lr ? (rr ? FREE : RO) : (rr ? LO : LO_RP);
      RO:      return rr ? (lq ? LO : FREE) : (lq ? RO_LP : RO);
      default: return rr ? (lr ? FREE : LO) : (lr ? RO : RO_LP);
    endcase
  endfunction

  task automatic drive(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic sel_n, output logic en, output logic wr_n,
                       output logic [AW-1:0] ao, output logic [DW-1:0] dout);
    ao = a; dout = d;
    case (op)
      OP_REQ:   begin sel_n = 0; en = 1; wr_n = 0; dout[0] = 1'b0; end
      OP_REL:   begin sel_n = 0; en = 1; wr_n = 0; dout[0] = 1'b1; end
      OP_BAD:   begin sel_n = 0; en = 0; wr_n = 0; dout[0] = 1'b0; end
      OP_DESEL: begin sel_n = 1; en = 1; wr_n = 0; dout[0] = 1'b0; end
      OP_RD:    begin sel_n = 0; en = 1; wr_n = 1; end
      default:  begin sel_n = 1; en = 0; wr_n = 1; end
    endcase
  endtask

  task automatic check(string tag, string side, int f, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s flag %0d: actual %h expected %h", tag, side, f, act, exp);
    end
  endtask

  task automatic sweep(string tag);
    l_sel_n = 0; l_en = 1; l_wr_n = 1; r_sel_n = 0; r_en = 1; r_wr_n = 1;
    for (int f = 0; f < NF; f++) begin
      lfsr = nxt(lfsr);
      l_addr = {lfsr[AW-1:3], 3'(f)};
      r_addr = {~lfsr[AW-1:3], 3'(f)};
      #0.3;
      check(tag, "left", f, l_rdata, (st[f] == LO || st[f] == LO_RP) ? '0 : '1);
      check(tag, "right", f, r_rdata, (st[f] == RO || st[f] == RO_LP) ? '0 : '1);
      checks++;
      if (l_rdata[0] === 1'b0 && r_rdata[0] === 1'b0) begin
        fails++;
        $display("FAIL R10 flag %0d: actual both 0 expected at most one", f);
      end
    end
  endtask

  task automatic step(string tag, int lop, logic [AW-1:0] la, logic [DW-1:0] ld,
                      int rop, logic [AW-1:0] ra, logic [DW-1:0] rd);
    @(negedge clk);
    drive(lop, la, ld, l_sel_n, l_en, l_wr_n, l_addr, l_wdata);
    drive(rop, ra, rd, r_sel_n, r_en, r_wr_n, r_addr, r_wdata);
    for (int f = 0; f < NF; f++)
      st[f] = model(st[f],
        lop == OP_REQ && la[2:0] == 3'(f), lop == OP_REL && la[2:0] == 3'(f),
        rop == OP_REQ && ra[2:0] == 3'(f), rop == OP_REL && ra[2:0] == 3'(f));
    @(posedge clk);
    #1;
    sweep(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) st[f] = FREE;
    l_sel_n = 0; l_en = 1; l_wr_n = 0; l_addr = 3; l_wdata = 0;
    r_sel_n = 0; r_en = 1; r_wr_n = 0; r_addr = 3; r_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    sweep("R1 reset");
    @(negedge clk) rst = 0;

    step("R3 R4 high addr bits", OP_REQ, 14'h3FFA, 16'h0000, OP_IDLE, 0, 0);
    step("R5 R6 request held flag", OP_RD, 14'h0002, 0, OP_REQ, 14'h2AAA, 16'hFFFE);
    step("R7 handoff on release", OP_REL, 14'h0002, 16'h0001, OP_IDLE, 0, 0);
    step("R11 release free", OP_IDLE, 0, 0, OP_REL, 14'h0002, 16'h0001);
    step("R8 left takes flag 5", OP_REQ, 14'h0005, 16'h1230, OP_IDLE, 0, 0);
    step("R8 right pends", OP_IDLE, 0, 0, OP_REQ, 14'h0005, 16'h0000);
    step("R8 right withdraws", OP_IDLE, 0, 0, OP_REL, 14'h1005, 16'hFFFF);
    step("R8 left releases", OP_REL, 14'h0005, 16'h0001, OP_IDLE, 0, 0);
    step("R9 same-cycle tie", OP_REQ, 14'h0007, 0, OP_REQ, 14'h0007, 0);
    step("R9 pending right granted", OP_REL, 14'h0007, 16'h0001, OP_IDLE, 0, 0);
    step("R2 illegal select write", OP_IDLE, 0, 0, OP_BAD, 14'h0007, 16'h0001);
    step("R2 deselected write", OP_DESEL, 14'h0003, 0, OP_BAD, 14'h0004, 0);
    step("R12 separate flags", OP_REQ, 14'h0000, 0, OP_REQ, 14'h0001, 0);
    step("R12 release one", OP_REL, 14'h0000, 16'h0001, OP_REL, 14'h0007, 16'h0001);

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] la, ra;
      logic [DW-1:0] ld, rd;
      int lop, rop;
      lfsr = nxt(lfsr); la = lfsr[AW-1:0];
      lfsr = nxt(lfsr); ra = lfsr[AW-1:0];
      lfsr = nxt(lfsr); ld = lfsr;
      lfsr = nxt(lfsr); rd = lfsr;
      lfsr = nxt(lfsr);
      lop = int'(lfsr[2:0]) % 6;
      rop = int'(lfsr[6:4]) % 6;
      if (lfsr[9:8] == 2'b00) ra[2:0] = la[2:0];
      step("R10 R12 random sweep", lop, la, ld, rop, ra, rd);
    end

    @(negedge clk) rst = 1;
    for (int f = 0; f < NF; f++) st[f] = FREE;
    @(posedge clk);
    #1;
    sweep("R1 reset after traffic");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule